// File: doc/BRIEF.md
# Miss-Frequency Load Candidate Selector

This block watches loads as they retire and decides which of them miss the first-level data cache often enough to be worth handing to a slice-extraction engine. Each cycle at most one retiring load is presented with its program counter and a flag that says whether it missed. The block keeps a small set-associative table, indexed by the load PC. Each entry holds a 4-bit saturating confidence counter.

A miss raises the counter sharply and a hit lowers it slowly. An entry is created only when a load misses. One cycle after a load whose updated counter is above 8, the block raises a single-cycle candidate pulse together with that load's PC. Whatever consumes the pulse sits outside this block.

The set index is taken from PC bits [IDX_W+1:2]. The remaining PC bits, including bits [1:0], form the tag. With the default parameters there are 16 sets of 4 ways.

Top module: `load_miss_candidate_sel`

## Requirements
- R1: While reset is asserted and after it is released, no entry is tracked and `cand_o` is low; a reset also forgets every counter learned before it.
- R2: A retiring load that misses and hits an existing entry raises that entry's counter by 4, saturating at 15 with no wraparound.
- R3: A retiring load that does not miss and hits an existing entry lowers its counter by 1, saturating at 0 with no wraparound.
- R4: A retiring load that misses and has no entry allocates one with counter value 4.
- R5: A retiring load that does not miss and has no entry allocates nothing, evicts nothing and raises no candidate.
- R6: `cand_o` is high for exactly the cycle after a retiring load whose counter, after that load's own update, is greater than 8, with `cand_pc_o` equal to that load's PC; a counter of exactly 8 does not select.
- R7: On allocation the lowest-numbered empty way of the set is used; when all ways are valid, the victim is the set's round-robin pointer, which starts at way 0 and advances by one (wrapping) only on such a replacement.
- R8: A cycle with `ret_valid_i` low changes no counter and gives a low `cand_o` in the next cycle.
- R9: One load is accepted per cycle, and back-to-back loads to the same PC each see the counter left by the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_valid_i | input | 1 | A load retires this cycle |
| ret_pc_i | input | PC_W | PC of the retiring load |
| ret_miss_i | input | 1 | The retiring load missed the first-level data cache |
| cand_o | output | 1 | One-cycle candidate pulse |
| cand_pc_o | output | PC_W | PC of the selected load, valid while `cand_o` is high |

## Verification
The counter update and the threshold test happen in the same cycle, because the decision must use the value written by that same load. The bench provokes this with miss sequences that step a counter from 8 to 12 and with hit sequences that step it from 9 to 8, and it expects the pulse to track the post-update value exactly. Allocation and victim eviction also coincide in one cycle when a set is full. This is judged by retiring, after the evictions, PCs that should still be resident and PCs that should have been displaced, and by reading from the pulse which of them kept their counts.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_MAX    = '1;
  localparam cnt_t ALLOC_VAL  = cnt_t'(4);
  localparam cnt_t MISS_INC   = cnt_t'(4);
  localparam cnt_t HIT_DEC    = cnt_t'(1);
  localparam cnt_t SEL_THRESH = cnt_t'(8);
endpackage

// File: rtl/lcs_way_match.sv
module lcs_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]            key_i,
  output logic [WAYS-1:0]             match_o,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = valid_i[w] && (tag_i[w] == key_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_o[w]) way_o = WAY_W'(w);
  end
endmodule

// File: rtl/lcs_victim.sv
module lcs_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_o
);
  // lowest empty way wins; round-robin only when the set is full
  always_comb begin
    way_o  = rr_i;
    full_o = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) begin
        way_o  = WAY_W'(w);
        full_o = 1'b0;
      end
  end
endmodule

// File: rtl/lcs_cnt_step.sv
module lcs_cnt_step
  import lcs_pkg::*;
(
  input  logic act_i,
  input  logic hit_i,
  input  logic miss_i,
  input  cnt_t cur_i,
  output cnt_t nxt_o,
  output logic wr_o,
  output logic sel_o
);
  logic [CNT_W:0] sum;

  always_comb begin
    sum = {1'b0, cur_i} + {1'b0, MISS_INC};
    if (!hit_i)
      nxt_o = ALLOC_VAL;
    else if (miss_i)
      nxt_o = (sum > {1'b0, CNT_MAX}) ? CNT_MAX : sum[CNT_W-1:0];
    else
      nxt_o = (cur_i < HIT_DEC) ? '0 : cur_i - HIT_DEC;
  end

  assign wr_o  = act_i && (hit_i || miss_i);
  assign sel_o = wr_o && (nxt_o > SEL_THRESH);
endmodule

// File: rtl/load_miss_candidate_sel.sv
module load_miss_candidate_sel
  import lcs_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ret_valid_i,
  input  logic [PC_W-1:0] ret_pc_i,
  input  logic            ret_miss_i,
  output logic            cand_o,
  output logic [PC_W-1:0] cand_pc_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - IDX_W;

  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][CNT_W-1:0]  cnt_q   [SETS];
  logic [WAY_W-1:0]            rr_q    [SETS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] key;
  assign idx = ret_pc_i[IDX_W+1:2];
  assign key = {ret_pc_i[PC_W-1:IDX_W+2], ret_pc_i[1:0]};

  logic [WAYS-1:0]  match_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way, vict_way, tgt_way;
  logic             set_full;
  cnt_t             cur_cnt, nxt_cnt;
  logic             wr_en, sel;

  lcs_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i (valid_q[idx]),
    .tag_i   (tag_q[idx]),
    .key_i   (key),
    .match_o (match_vec),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  lcs_victim #(.WAYS(WAYS)) u_victim (
    .valid_i (valid_q[idx]),
    .rr_i    (rr_q[idx]),
    .way_o   (vict_way),
    .full_o  (set_full)
  );

  assign tgt_way = hit ? hit_way : vict_way;
  assign cur_cnt = cnt_q[idx][hit_way];

  lcs_cnt_step u_step (
    .act_i  (ret_valid_i),
    .hit_i  (hit),
    .miss_i (ret_miss_i),
    .cur_i  (cur_cnt),
    .nxt_o  (nxt_cnt),
    .wr_o   (wr_en),
    .sel_o  (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tag_q[s]   <= '0;
        cnt_q[s]   <= '0;
        rr_q[s]    <= '0;
      end
      cand_o    <= 1'b0;
      cand_pc_o <= '0;
    end else begin
      cand_o <= sel;
      if (sel) cand_pc_o <= ret_pc_i;
      if (wr_en) begin
        valid_q[idx][tgt_way] <= 1'b1;
        tag_q[idx][tgt_way]   <= key;
        cnt_q[idx][tgt_way]   <= nxt_cnt;
        if (!hit && set_full)
          rr_q[idx] <= (rr_q[idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[idx] + 1'b1;
      end
    end
  end

  p_one_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |-> $onehot0(match_vec));

  p_miss_grow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_miss_i && hit) |-> (nxt_cnt >= cur_cnt));

  p_hit_shrink_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !ret_miss_i && hit) |-> (nxt_cnt <= cur_cnt));

  p_alloc_val_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_miss_i && !hit) |-> (nxt_cnt == ALLOC_VAL));

  p_no_alloc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !ret_miss_i && !hit) |-> !wr_en);

  p_fire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && nxt_cnt > SEL_THRESH) |=> (cand_o && cand_pc_o == $past(ret_pc_i)));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_valid_i |=> !cand_o);
endmodule

// File: tb/load_miss_candidate_sel_tb_top.sv
module load_miss_candidate_sel_tb_top;
  localparam int PC_W = 32;
  localparam int NV   = 56;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ret_valid_i = 1'b0;
  logic [PC_W-1:0] ret_pc_i = '0;
  logic            ret_miss_i = 1'b0;
  logic            cand_o;
  logic [PC_W-1:0] cand_pc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  load_miss_candidate_sel dut_i (
    .clk_i, .rst_ni, .ret_valid_i, .ret_pc_i, .ret_miss_i, .cand_o, .cand_pc_o
  );

  // {valid, miss, expected cand, pc}
  localparam logic [34:0] VEC [NV] = '{
    // A: set 0, up, saturate at 15, down to 8
    {3'b110, 32'h1000}, {3'b110, 32'h1000}, {3'b111, 32'h1000},
    {3'b101, 32'h1000}, {3'b101, 32'h1000}, {3'b101, 32'h1000},
    {3'b100, 32'h1000}, {3'b111, 32'h1000}, {3'b111, 32'h1000},
    {3'b101, 32'h1000}, {3'b101, 32'h1000}, {3'b101, 32'h1000},
    {3'b101, 32'h1000}, {3'b101, 32'h1000}, {3'b101, 32'h1000},
    {3'b100, 32'h1000},
    // B: set 1, floor at 0
    {3'b110, 32'h2004}, {3'b100, 32'h2004}, {3'b100, 32'h2004},
    {3'b100, 32'h2004}, {3'b100, 32'h2004}, {3'b100, 32'h2004},
    {3'b110, 32'h2004}, {3'b110, 32'h2004}, {3'b111, 32'h2004},
    // C: set 3, untracked hit then misses
    {3'b100, 32'h300C}, {3'b110, 32'h300C}, {3'b110, 32'h300C},
    {3'b111, 32'h300C},
    // idle cycles with a miss on A presented, then A at 8 -> 7 -> 11
    {3'b010, 32'h1000}, {3'b010, 32'h1000}, {3'b010, 32'h1000},
    {3'b100, 32'h1000}, {3'b111, 32'h1000},
    // set 2: fill four ways to 8
    {3'b110, 32'h0008}, {3'b110, 32'h0048}, {3'b110, 32'h0088},
    {3'b110, 32'h00C8}, {3'b110, 32'h0008}, {3'b110, 32'h0048},
    {3'b110, 32'h0088}, {3'b110, 32'h00C8},
    // untracked hit, then replacements in round-robin order
    {3'b100, 32'h0108}, {3'b111, 32'h0008}, {3'b110, 32'h0108},
    {3'b110, 32'h0008}, {3'b111, 32'h0088}, {3'b111, 32'h00C8},
    {3'b110, 32'h0108}, {3'b110, 32'h0008}, {3'b110, 32'h0048},
    {3'b110, 32'h0088}, {3'b110, 32'h00C8}, {3'b111, 32'h0008},
    {3'b110, 32'h0108}, {3'b110, 32'h0008}
  };

  function automatic string vec_req(int i);
    if (i < 16) return "R2 R6 R9";
    if (i < 25) return "R3";
    if (i < 29) return "R4 R5";
    if (i < 34) return "R8";
    return "R7 R5";
  endfunction

  task automatic check(input bit ok, input string req, input logic [PC_W-1:0] act,
                       input logic [PC_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(input logic v, input logic m, input logic [PC_W-1:0] pc,
                      input logic exp, input string req);
    ret_valid_i = v;
    ret_miss_i  = m;
    ret_pc_i    = pc;
    @(negedge clk_i);
    check(cand_o == exp, req, PC_W'(cand_o), PC_W'(exp));
    if (exp) check(cand_pc_o == pc, req, cand_pc_o, pc);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(cand_o == 1'b0, "R1", PC_W'(cand_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cand_o == 1'b0, "R1", PC_W'(cand_o), '0);

    for (int i = 0; i < NV; i++)
      step(VEC[i][34], VEC[i][33], VEC[i][31:0], VEC[i][32], vec_req(i));

    // A is at 11; reset must forget it
    @(negedge clk_i);
    rst_ni = 1'b0;
    ret_valid_i = 1'b0;
    @(negedge clk_i);
    check(cand_o == 1'b0, "R1", PC_W'(cand_o), '0);
    rst_ni = 1'b1;
    step(1'b1, 1'b1, 32'h1000, 1'b0, "R1");
    step(1'b1, 1'b1, 32'h1000, 1'b0, "R1");
    step(1'b1, 1'b1, 32'h1000, 1'b1, "R1");
    step(1'b0, 1'b0, 32'h1000, 1'b0, "R8");
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule